// File: doc/BRIEF.md
# Event Counter and Watchdog with Shared Prescaler

This block holds an 8-bit event counter and an 8-bit watchdog that share one 8-bit prescaler. An 8-bit control register configures them. The counter advances either on an internal cycle tick or on a chosen edge of an external pin. That pin passes through a two-flop synchronizer before edges are detected. The prescaler divides events for only one consumer at a time. If it serves the counter, the counter sees one step every 2^(rate+1) source events and the watchdog takes every cycle tick. If it serves the watchdog, the watchdog sees one step every 2^rate cycle ticks and the counter runs undivided.

A wrap of the counter from all-ones to zero raises a one-clock interrupt pulse unless the active-low mask bit blocks it. A wrap of the watchdog gives a one-clock timeout pulse. Software can clear the watchdog, load the counter and rewrite the control register. Each of these actions also empties the prescaler. A lock input can pin the two top control bits at 1. The top bit drives an output that selects whether a shared register address reaches the counter or the working register.

Top module: `tmr_shared_prescale`

## Requirements
- R1: After reset the control register reads 0xFF, the counter reads 0x00, the interrupt and timeout outputs are low, and the mapping-select output is high.
- R2: With the lock input at 0, the control register reads back the value last written. With the lock input at 1, bits 7 and 6 read as 1 whatever was written, and writes made while locked do not change the stored bits 7 and 6.
- R3: The mapping-select output follows bit 7 of the control register as read back.
- R4: With bit 5 = 0, the counter source is the cycle tick. With bit 3 = 1, the counter advances by one on each clock that has the tick high, and the external pin has no effect.
- R5: With bit 5 = 1, the counter source is the external pin after a two-flop synchronizer. Bit 4 = 0 counts rising edges and bit 4 = 1 counts falling edges. The cycle tick has no effect in this mode.
- R6: With bit 3 = 0, the prescaler serves the counter. Rate field bits 2:0 = r make the counter advance once per 2^(r+1) source events, counted from the last prescaler clear.
- R7: With bit 3 = 1, the prescaler serves the watchdog. The watchdog advances once per 2^r cycle ticks, and the counter runs 1:1.
- R8: The watchdog times out when it wraps from 0xFF. The timeout output is high for exactly one clock. With bit 3 = 0, the watchdog advances on every cycle tick.
- R9: When the counter wraps from 0xFF to 0x00 with bit 6 = 0, the interrupt output pulses high for one clock. With bit 6 = 1, no pulse is produced.
- R10: A counter write loads the value, which reads back at once. A counter write or a control write also clears the prescaler count.
- R11: The watchdog clear input resets both the watchdog count and the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_tick_i | input | 1 | Internal cycle tick, one event per high clock |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| fuse_lock_i | input | 1 | 1 forces control bits 7:6 to 1 |
| opt_we_i | input | 1 | Control register write strobe |
| opt_wdata_i | input | 8 | Control register write data |
| opt_rdata_o | output | 8 | Control register read data |
| cnt_we_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 8 | Counter load value |
| cnt_rdata_o | output | 8 | Counter value |
| wdt_clr_i | input | 1 | Watchdog and prescaler clear |
| irq_o | output | 1 | Counter wrap interrupt pulse |
| wdt_timeout_o | output | 1 | Watchdog timeout pulse |
| map_sel_o | output | 1 | 1 maps the shared address to the counter, 0 to the working register |

## Verification
The assertions assume only that reset is applied before any strobe. They put no limit on how write strobes, clears and ticks fall, so load, clear and advance are checked in every combination. Because the external pin is asynchronous, no property refers to it directly; the edge checks look only at synchronized state. The bench drives every input on the falling clock edge, holds the pin low through reset, and keeps each pin level for at least four clocks so the synchronizer captures every transition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OPT_W  = 8;
  localparam int unsigned RATE_W = 3;

  // bit order is decoded by the routing logic
  typedef struct packed {
    logic              map_sel;    // 7
    logic              irq_dis;    // 6, active low enable
    logic              ext_src;    // 5
    logic              fall_edge;  // 4
    logic              ps_to_wdt;  // 3
    logic [RATE_W-1:0] rate;       // 2:0
  } opt_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise   = sync_q[STAGES-1] & ~prev_q;
  assign fall   = ~sync_q[STAGES-1] & prev_q;
  assign edge_o = fall_sel_i ? fall : rise;

  p_one_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise, fall}));
  p_edge_hist_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> prev_q);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler import tmr_pkg::*; #(
  parameter int unsigned PS_W = 1 << RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ev_i,
  input  logic              to_wdt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tc_o
);
  logic [PS_W-1:0] ps_q, mask;

  // counter side uses bits rate..0, watchdog side bits below rate
  always_comb begin
    for (int i = 0; i < PS_W; i++)
      mask[i] = to_wdt_i ? (i < int'(rate_i)) : (i <= int'(rate_i));
  end

  assign tc_o = ev_i && ((ps_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ps_q <= '0;
    else if (clr_i) ps_q <= '0;
    else if (ev_i)  ps_q <= ps_q + 1'b1;
  end

  p_ps_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ps_q == '0);
  p_ps_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ev_i) |=> ps_q == PS_W'($past(ps_q) + 1'b1));
  p_ps_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ev_i) |=> $stable(ps_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             adv_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (we_i)       cnt_q <= wdata_i;
      else if (adv_i) cnt_q <= cnt_q + 1'b1;
      irq_q <= !we_i && adv_i && irq_en_i && (&cnt_q);
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cnt_q == $past(wdata_i));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && adv_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !adv_i) |=> $stable(cnt_q));
  p_irq_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_q == '0);
  p_irq_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o);
  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog #(
  parameter int unsigned WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic timeout_o
);
  logic [WDT_W-1:0] wdt_q;
  logic             to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      if (clr_i)      wdt_q <= '0;
      else if (adv_i) wdt_q <= wdt_q + 1'b1;
      to_q <= !clr_i && adv_i && (&wdt_q);
    end
  end

  assign timeout_o = to_q;

  p_wdt_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wdt_q == '0) && !timeout_o);
  p_wdt_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> wdt_q == '0);
  p_wdt_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

// File: rtl/tmr_shared_prescale.sv
module tmr_shared_prescale import tmr_pkg::*; #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WDT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_tick_i,
  input  logic             ext_pin_i,
  input  logic             fuse_lock_i,
  input  logic             opt_we_i,
  input  logic [OPT_W-1:0] opt_wdata_i,
  output logic [OPT_W-1:0] opt_rdata_o,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_rdata_o,
  input  logic             wdt_clr_i,
  output logic             irq_o,
  output logic             wdt_timeout_o,
  output logic             map_sel_o
);
  localparam int unsigned PS_W = 1 << RATE_W;

  logic [OPT_W-1:0] opt_q;
  opt_t             opt;
  logic             pin_edge, src_ev, ps_ev, ps_tc, ps_clr, cnt_adv, wdt_adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) opt_q <= '1;
    else if (opt_we_i) begin
      opt_q[OPT_W-3:0] <= opt_wdata_i[OPT_W-3:0];
      if (!fuse_lock_i) opt_q[OPT_W-1:OPT_W-2] <= opt_wdata_i[OPT_W-1:OPT_W-2];
    end
  end

  // locked top bits behave as set everywhere, not only on read
  assign opt         = fuse_lock_i ? opt_t'({2'b11, opt_q[OPT_W-3:0]}) : opt_t'(opt_q);
  assign opt_rdata_o = opt;
  assign map_sel_o   = opt.map_sel;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .pin_i      (ext_pin_i),
    .fall_sel_i (opt.fall_edge),
    .edge_o     (pin_edge)
  );

  assign src_ev  = opt.ext_src ? pin_edge : cyc_tick_i;
  assign ps_ev   = opt.ps_to_wdt ? cyc_tick_i : src_ev;
  assign cnt_adv = opt.ps_to_wdt ? src_ev : ps_tc;
  assign wdt_adv = opt.ps_to_wdt ? ps_tc : cyc_tick_i;
  assign ps_clr  = cnt_we_i | opt_we_i | wdt_clr_i;

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i, .rst_ni,
    .clr_i    (ps_clr),
    .ev_i     (ps_ev),
    .to_wdt_i (opt.ps_to_wdt),
    .rate_i   (opt.rate),
    .tc_o     (ps_tc)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .we_i     (cnt_we_i),
    .wdata_i  (cnt_wdata_i),
    .adv_i    (cnt_adv),
    .irq_en_i (~opt.irq_dis),
    .cnt_o    (cnt_rdata_o),
    .irq_o    (irq_o)
  );

  tmr_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk_i, .rst_ni,
    .clr_i     (wdt_clr_i),
    .adv_i     (wdt_adv),
    .timeout_o (wdt_timeout_o)
  );

  p_opt_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_we_i && !fuse_lock_i) |=> fuse_lock_i || (opt_rdata_o == $past(opt_wdata_i)));
  p_opt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!opt_we_i && !fuse_lock_i) |=> fuse_lock_i || $stable(opt_rdata_o));
  p_map_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!opt_we_i && $stable(fuse_lock_i)) |=> $stable(map_sel_o));
endmodule

// File: tb/tmr_shared_prescale_tb.sv
module tmr_shared_prescale_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cyc_tick_i = 1'b0, ext_pin_i = 1'b0, fuse_lock_i = 1'b0;
  logic       opt_we_i = 1'b0, cnt_we_i = 1'b0, wdt_clr_i = 1'b0;
  logic [7:0] opt_wdata_i = '0, cnt_wdata_i = '0;
  logic [7:0] opt_rdata_o, cnt_rdata_o;
  logic       irq_o, wdt_timeout_o, map_sel_o;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, to_cnt = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tmr_shared_prescale u_dut (.*);

  always @(posedge clk_i) begin
    if (irq_o) irq_cnt++;
    if (wdt_timeout_o) to_cnt++;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic tick(int n);
    @(negedge clk_i) cyc_tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cyc_tick_i = 1'b0;
  endtask

  task automatic wr_opt(logic [7:0] v);
    @(negedge clk_i) begin opt_we_i = 1'b1; opt_wdata_i = v; end
    @(negedge clk_i) opt_we_i = 1'b0;
  endtask

  task automatic wr_cnt(logic [7:0] v);
    @(negedge clk_i) begin cnt_we_i = 1'b1; cnt_wdata_i = v; end
    @(negedge clk_i) cnt_we_i = 1'b0;
  endtask

  task automatic clr_wdt();
    @(negedge clk_i) wdt_clr_i = 1'b1;
    @(negedge clk_i) wdt_clr_i = 1'b0;
  endtask

  task automatic pin(logic v);
    @(negedge clk_i) ext_pin_i = v;
    idle(4);
  endtask

  task automatic t_reset();
    chk("R1 opt", opt_rdata_o, 8'hFF);
    chk("R1 cnt", cnt_rdata_o, 8'h00);
    chk("R1 irq", irq_o, 0);
    chk("R1 timeout", wdt_timeout_o, 0);
    chk("R1 map_sel", map_sel_o, 1);
  endtask

  task automatic t_fuse();
    wr_opt(8'h28);
    chk("R2 readback", opt_rdata_o, 8'h28);
    chk("R3 map_sel low", map_sel_o, 0);
    fuse_lock_i = 1'b1; idle(1);
    chk("R2 locked view", opt_rdata_o, 8'hE8);
    chk("R3 map_sel locked", map_sel_o, 1);
    wr_opt(8'h00);
    chk("R2 locked write", opt_rdata_o, 8'hC0);
    fuse_lock_i = 1'b0; idle(1);
    chk("R2 unlocked bits kept", opt_rdata_o, 8'h00);
    wr_opt(8'hA8);
    chk("R3 map_sel high", map_sel_o, 1);
  endtask

  task automatic t_internal();
    wr_opt(8'h08);
    wr_cnt(8'h10);
    tick(5);
    chk("R4 tick count", cnt_rdata_o, 8'h15);
    pin(1'b1); pin(1'b0); pin(1'b1); pin(1'b0);
    chk("R4 pin ignored", cnt_rdata_o, 8'h15);
  endtask

  task automatic t_external();
    wr_opt(8'h28);
    wr_cnt(8'h00);
    pin(1'b1);
    chk("R5 rise counted", cnt_rdata_o, 8'h01);
    pin(1'b0);
    chk("R5 fall ignored", cnt_rdata_o, 8'h01);
    tick(3);
    chk("R5 tick ignored", cnt_rdata_o, 8'h01);
    wr_opt(8'h38);
    pin(1'b1);
    chk("R5 rise ignored", cnt_rdata_o, 8'h01);
    pin(1'b0);
    chk("R5 fall counted", cnt_rdata_o, 8'h02);
  endtask

  task automatic t_ps_counter();
    wr_opt(8'h02);
    wr_cnt(8'h00);
    tick(7);
    chk("R6 1:8 before", cnt_rdata_o, 8'h00);
    tick(1);
    chk("R6 1:8 step", cnt_rdata_o, 8'h01);
    tick(16);
    chk("R6 1:8 more", cnt_rdata_o, 8'h03);
    wr_opt(8'h07);
    wr_cnt(8'h00);
    tick(255);
    chk("R6 1:256 before", cnt_rdata_o, 8'h00);
    tick(1);
    chk("R6 1:256 step", cnt_rdata_o, 8'h01);
  endtask

  task automatic t_ps_wdt();
    int base;
    wr_opt(8'h0B);
    wr_cnt(8'h00);
    clr_wdt();
    base = to_cnt;
    tick(2047); idle(1);
    chk("R7 counter 1:1", cnt_rdata_o, 8'hFF);
    chk("R7 no early timeout", to_cnt - base, 0);
    tick(1); idle(1);
    chk("R7 timeout at 2048", to_cnt - base, 1);
  endtask

  task automatic t_wdt_direct();
    int base;
    wr_opt(8'h00);
    clr_wdt();
    base = to_cnt;
    tick(255); idle(1);
    chk("R8 no timeout at 255", to_cnt - base, 0);
    tick(1);
    chk("R8 timeout high", wdt_timeout_o, 1);
    idle(1);
    chk("R8 timeout low next", wdt_timeout_o, 0);
    chk("R8 single pulse", to_cnt - base, 1);
  endtask

  task automatic t_irq();
    int base;
    wr_opt(8'h08);
    wr_cnt(8'hFE);
    base = irq_cnt;
    tick(1); idle(1);
    chk("R9 at FF", cnt_rdata_o, 8'hFF);
    chk("R9 no irq yet", irq_cnt - base, 0);
    tick(1);
    chk("R9 wrapped", cnt_rdata_o, 8'h00);
    chk("R9 irq high", irq_o, 1);
    idle(1);
    chk("R9 one pulse", irq_cnt - base, 1);
    wr_opt(8'h48);
    wr_cnt(8'hFE);
    base = irq_cnt;
    tick(2); idle(2);
    chk("R9 masked wrap", cnt_rdata_o, 8'h00);
    chk("R9 masked no irq", irq_cnt - base, 0);
  endtask

  task automatic t_write_clear();
    wr_opt(8'h02);
    wr_cnt(8'h40);
    chk("R10 load", cnt_rdata_o, 8'h40);
    tick(5);
    wr_cnt(8'h40);
    tick(7);
    chk("R10 cnt write clears ps", cnt_rdata_o, 8'h40);
    tick(1);
    chk("R10 step after clear", cnt_rdata_o, 8'h41);
    tick(5);
    wr_opt(8'h02);
    tick(7);
    chk("R10 opt write clears ps", cnt_rdata_o, 8'h41);
    tick(1);
    chk("R10 step after opt", cnt_rdata_o, 8'h42);
  endtask

  task automatic t_wdt_clear();
    int base;
    wr_opt(8'h08);
    clr_wdt();
    base = to_cnt;
    tick(200);
    clr_wdt();
    tick(255); idle(1);
    chk("R11 clear restarts wdt", to_cnt - base, 0);
    tick(1); idle(1);
    chk("R11 timeout after clear", to_cnt - base, 1);
    wr_opt(8'h0A);
    clr_wdt();
    tick(3);
    clr_wdt();
    base = to_cnt;
    tick(1023); idle(1);
    chk("R11 ps cleared", to_cnt - base, 0);
    tick(1); idle(1);
    chk("R11 timeout 1:4", to_cnt - base, 1);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_fuse();
    t_internal();
    t_external();
    t_ps_counter();
    t_ps_wdt();
    t_wdt_direct();
    t_irq();
    t_write_clear();
    t_wdt_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule